// File: doc/BRIEF.md
# Constant-Weight Three-Channel Error-Correcting Receiver

This block sits behind three parallel 4-wire constant-weight channels. Each channel carries a 4-bit symbol with exactly two bits set. The six legal symbols form three subsets of two complementary members. Each received symbol therefore carries a base-3 subset digit and one member bit. The first two digits encode a 3-bit value. The third digit is a modulo-3 check digit, chosen so that the three digits sum to zero. The block rebuilds the 6-bit payload from the digits and member bits.

A symbol whose weight is not two is treated as an erasure. Its subset is the one that makes the digit sum zero modulo 3. The symbol is then replaced by whichever member of that subset lies nearer in Hamming distance.

Words enter and results leave through valid/ready streams. There are two register stages, so an unstalled word appears two cycles after it is accepted. A transfer happens on a clock edge where valid and ready are both high. Once `out_valid` is raised, the payload and the flags hold until `out_ready` takes them. `in_ready` is low only while both stages are occupied and the output is stalled. No word is dropped, duplicated or reordered.

Top module: `nck_ecc_decoder`

## Requirements
- R1: Channel 0 is `in_word[11:8]`, channel 1 is `in_word[7:4]` and channel 2 is `in_word[3:0]`. A symbol is legal only when exactly two of its bits are set. Subset 0 is {0011, 1100}, subset 1 is {0101, 1010} and subset 2 is {0110, 1001}. The member bit of a legal symbol is its bit 3.
- R2: Let d0, d1 be the digits and m0, m1, m2 the member bits of channels 0, 1 and 2. For a word of three legal symbols whose digits sum to 0 mod 3, `out_payload[5:3]` = 3*d0 + d1 and `out_payload[2:0]` = {m0, m1, m2}. No flag is raised, and every one of the 64 payloads makes this round trip.
- R3: When exactly one symbol has weight 1 or 3, its digit is set to the one that makes the three digits sum to 0 mod 3. The nearer member of that subset then replaces it, and `out_corrected` is raised with the original payload.
- R4: When exactly one symbol has weight 0 or 4, it is equally distant from both members of its subset. `out_uncorrectable` is raised and the payload is 0.
- R5: When two or more symbols are illegal, `out_uncorrectable` is raised and the payload is 0.
- R6: When all three symbols are legal but their digits do not sum to 0 mod 3, `out_chk_err` is raised and `out_corrected` stays low. The payload is formed from the received digits as in R2.
- R7: When the digit pair (d0, d1), after any repair, is (2, 2), `out_uncorrectable` is raised and the payload is 0. If R6 also applies, `out_chk_err` is raised as well.
- R8: `out_corrected` is never raised together with another flag.
- R9: An accepted word appears on the output two cycles later if nothing stalls. Output values hold while `out_valid` is high and `out_ready` is low. Results leave in acceptance order, and at most two words are in flight.
- R10: While `rst_n` is low, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Received word is present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | 12 | Three received symbols, channel 0 in the top nibble |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_payload | output | 6 | Recovered payload |
| out_corrected | output | 1 | One illegal symbol was repaired |
| out_uncorrectable | output | 1 | Word could not be recovered, payload forced to 0 |
| out_chk_err | output | 1 | Legal symbols whose digit sum is not 0 mod 3 |

## Verification
Two functions can meet in one cycle. An erasure repair can be computed in the second stage at the moment the output register stalls, while a new word is accepted into the first stage. The bench provokes this by streaming mixed clean, repaired and unrecoverable words with random gaps against a randomly toggling `out_ready`. A behavioural model pushes an expected result into a queue on every acceptance and pops one on every output transfer. The model finds the nearest codeword by searching all 64 payloads. On every stalled cycle the bench also checks that the offered result stayed unchanged.

// File: rtl/nck_pkg.sv
package nck_pkg;
  localparam int SYM_W  = 4;
  localparam int N_CH   = 3;
  localparam int DIG_W  = 2;
  localparam int PAY_W  = 6;
  localparam int WORD_W = SYM_W * N_CH;
  localparam int CNT_W  = $clog2(N_CH + 1);
  localparam int SUM_W  = $clog2(2 * N_CH + 1);
  localparam int DST_W  = $clog2(SYM_W + 1);

  typedef struct packed {
    logic             ok;
    logic [DIG_W-1:0] dig;
    logic             mb;
    logic [SYM_W-1:0] raw;
  } sym_info_t;

  typedef struct packed {
    logic [PAY_W-1:0] pay;
    logic             corr;
    logic             unc;
    logic             chk;
  } dec_res_t;

  function automatic logic [SYM_W-1:0] member_sym(input logic [DIG_W-1:0] d, input logic b);
    case ({d, b})
      3'b000:  member_sym = 4'b0011;
      3'b001:  member_sym = 4'b1100;
      3'b010:  member_sym = 4'b0101;
      3'b011:  member_sym = 4'b1010;
      3'b100:  member_sym = 4'b0110;
      3'b101:  member_sym = 4'b1001;
      default: member_sym = 4'b0000;
    endcase
  endfunction

  function automatic logic [DST_W-1:0] weight(input logic [SYM_W-1:0] v);
    logic [DST_W-1:0] w;
    w = '0;
    for (int i = 0; i < SYM_W; i++) w = w + DST_W'(v[i]);
    return w;
  endfunction

  function automatic logic [DIG_W-1:0] mod3(input logic [SUM_W-1:0] v);
    return DIG_W'(v % SUM_W'(3));
  endfunction
endpackage

// File: rtl/nck_sym_classify.sv
module nck_sym_classify
  import nck_pkg::*;
(
  input  logic [SYM_W-1:0] sym,
  output sym_info_t        info
);
  logic [DIG_W-1:0] dig;

  always_comb begin
    if (sym[3] == sym[2])      dig = 2'd0;
    else if (sym[3] == sym[1]) dig = 2'd1;
    else                       dig = 2'd2;
  end

  assign info.ok  = (weight(sym) == DST_W'(2));
  assign info.dig = dig;
  assign info.mb  = sym[SYM_W-1];
  assign info.raw = sym;
endmodule

// File: rtl/nck_erasure_resolver.sv
module nck_erasure_resolver
  import nck_pkg::*;
(
  input  sym_info_t [N_CH-1:0] info,
  output dec_res_t             res
);
  logic [CNT_W-1:0] nbad;
  logic [SUM_W-1:0] sum_good;
  logic [SYM_W-1:0] raw_bad;
  logic [DIG_W-1:0] rem;
  logic [DIG_W-1:0] missing;
  logic [DST_W-1:0] dist0, dist1;
  logic             tie, fix_mb;
  logic [DIG_W-1:0] dig_f [N_CH];
  logic             mb_f  [N_CH];
  logic [3:0]       s_val;
  logic             pair22;
  logic             unc;

  always_comb begin
    nbad     = '0;
    sum_good = '0;
    raw_bad  = '0;
    for (int ch = 0; ch < N_CH; ch++) begin
      if (info[ch].ok) begin
        sum_good = sum_good + SUM_W'(info[ch].dig);
      end else begin
        nbad    = nbad + CNT_W'(1);
        raw_bad = info[ch].raw;
      end
    end
  end

  assign rem     = mod3(sum_good);
  assign missing = (rem == 2'd0) ? 2'd0 : (2'd3 - rem);
  assign dist0   = weight(raw_bad ^ member_sym(missing, 1'b0));
  assign dist1   = weight(raw_bad ^ member_sym(missing, 1'b1));
  assign tie     = (dist0 == dist1);
  assign fix_mb  = (dist1 < dist0);

  always_comb begin
    for (int ch = 0; ch < N_CH; ch++) begin
      dig_f[ch] = info[ch].ok ? info[ch].dig : missing;
      mb_f[ch]  = info[ch].ok ? info[ch].mb  : fix_mb;
    end
  end

  assign s_val  = 4'(dig_f[0]) * 4'd3 + 4'(dig_f[1]);
  assign pair22 = (dig_f[0] == 2'd2) && (dig_f[1] == 2'd2);

  assign unc = (nbad >= CNT_W'(2)) || ((nbad == CNT_W'(1)) && tie) || pair22;

  assign res.unc  = unc;
  assign res.corr = (nbad == CNT_W'(1)) && !unc;
  assign res.chk  = (nbad == '0) && (rem != 2'd0);
  assign res.pay  = unc ? '0 : {s_val[2:0], mb_f[0], mb_f[1], mb_f[2]};
endmodule

// File: rtl/nck_pipe_reg.sv
module nck_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         v;
  logic [W-1:0] q;

  assign up_ready = !v || dn_ready;
  assign dn_valid = v;
  assign dn_data  = q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v <= 1'b0;
      q <= '0;
    end else if (up_ready) begin
      v <= up_valid;
      if (up_valid) q <= up_data;
    end
  end
endmodule

// File: rtl/nck_ecc_decoder.sv
module nck_ecc_decoder
  import nck_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PAY_W-1:0]  out_payload,
  output logic              out_corrected,
  output logic              out_uncorrectable,
  output logic              out_chk_err
);
  localparam int S1_W = $bits(sym_info_t) * N_CH;
  localparam int S2_W = $bits(dec_res_t);

  sym_info_t [N_CH-1:0] cls_info;
  sym_info_t [N_CH-1:0] s1_info;
  logic [S1_W-1:0]      s1_q;
  logic                 s1_valid, s1_ready;
  dec_res_t             res_d, res_q;
  logic [S2_W-1:0]      s2_q;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_cls
    nck_sym_classify u_cls (
      .sym  (in_word[WORD_W-1-ch*SYM_W -: SYM_W]),
      .info (cls_info[ch])
    );
  end

  nck_pipe_reg #(.W(S1_W)) u_s1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (cls_info),
    .dn_valid (s1_valid),
    .dn_ready (s1_ready),
    .dn_data  (s1_q)
  );

  assign s1_info = s1_q;

  nck_erasure_resolver u_res (
    .info (s1_info),
    .res  (res_d)
  );

  nck_pipe_reg #(.W(S2_W)) u_s2 (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (s1_valid),
    .up_ready (s1_ready),
    .up_data  (res_d),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (s2_q)
  );

  assign res_q             = s2_q;
  assign out_payload       = res_q.pay;
  assign out_corrected     = res_q.corr;
  assign out_uncorrectable = res_q.unc;
  assign out_chk_err       = res_q.chk;
endmodule

// File: rtl/nck_ecc_decoder_chk.sv
module nck_ecc_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [5:0] out_payload,
  input logic       out_corrected,
  input logic       out_uncorrectable,
  input logic       out_chk_err
);
  logic [2:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 3'(in_valid && in_ready) - 3'(out_valid && out_ready);
  end

  a_r8_corr_alone: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_corrected |-> !out_uncorrectable && !out_chk_err);

  a_r5_unc_payload_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_uncorrectable |-> out_payload == 6'd0);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_payload) && $stable(out_corrected)
      && $stable(out_uncorrectable) && $stable(out_chk_err));

  a_r9_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 3'd2);

  a_r9_ready_only_blocked_by_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready);

  a_r9_output_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != 3'd0);
endmodule

bind nck_ecc_decoder nck_ecc_decoder_chk u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .in_valid          (in_valid),
  .in_ready          (in_ready),
  .out_valid         (out_valid),
  .out_ready         (out_ready),
  .out_payload       (out_payload),
  .out_corrected     (out_corrected),
  .out_uncorrectable (out_uncorrectable),
  .out_chk_err       (out_chk_err)
);

// File: tb/nck_ecc_decoder_test.sv
module nck_ecc_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [5:0]  out_payload;
  logic        out_corrected, out_uncorrectable, out_chk_err;

  always #5 clk = ~clk;

  nck_ecc_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_payload(out_payload),
    .out_corrected(out_corrected), .out_uncorrectable(out_uncorrectable), .out_chk_err(out_chk_err)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  bit rnd_rdy = 0;

  logic [8:0] q_exp[$];
  int         q_cyc[$];
  bit         q_free[$];
  string      q_tag[$];

  bit         prev_stall = 0;
  logic [8:0] prev_out;

  function automatic logic [3:0] sym_of(int d, int b);
    case (d * 2 + b)
      0: return 4'b0011;
      1: return 4'b1100;
      2: return 4'b0101;
      3: return 4'b1010;
      4: return 4'b0110;
      default: return 4'b1001;
    endcase
  endfunction

  function automatic int dig_of(logic [3:0] s);
    case (s)
      4'b0011, 4'b1100: return 0;
      4'b0101, 4'b1010: return 1;
      4'b0110, 4'b1001: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic logic [11:0] enc(int p);
    int s, d0, d1, d2;
    s  = p / 8;
    d0 = s / 3;
    d1 = s % 3;
    d2 = (6 - d0 - d1) % 3;
    return {sym_of(d0, (p >> 2) & 1), sym_of(d1, (p >> 1) & 1), sym_of(d2, p & 1)};
  endfunction

  function automatic logic [3:0] nib(logic [11:0] w, int ch);
    return w[11 - 4*ch -: 4];
  endfunction

  function automatic int hd(logic [3:0] a, logic [3:0] b);
    return $countones(a ^ b);
  endfunction

  // expected {payload, corrected, uncorrectable, chk_err}
  function automatic logic [8:0] model(logic [11:0] w);
    int nb, bad, best, nbest, bestp, dsum;
    int d[3];
    nb = 0; bad = 0;
    for (int ch = 0; ch < 3; ch++) begin
      d[ch] = dig_of(nib(w, ch));
      if (d[ch] < 0) begin nb++; bad = ch; end
    end
    if (nb >= 2) return {6'd0, 3'b010};
    if (nb == 1) begin
      best = 99; nbest = 0; bestp = 0;
      for (int p = 0; p < 64; p++) begin
        logic [11:0] c;
        bit agree;
        c = enc(p);
        agree = 1;
        for (int ch = 0; ch < 3; ch++)
          if (ch != bad && nib(c, ch) != nib(w, ch)) agree = 0;
        if (agree) begin
          if (hd(nib(c, bad), nib(w, bad)) < best) begin
            best = hd(nib(c, bad), nib(w, bad)); nbest = 1; bestp = p;
          end else if (hd(nib(c, bad), nib(w, bad)) == best) nbest++;
        end
      end
      if (nbest != 1) return {6'd0, 3'b010};
      return {6'(bestp), 3'b100};
    end
    for (int p = 0; p < 64; p++) if (enc(p) == w) return {6'(p), 3'b000};
    dsum = (d[0] + d[1] + d[2]) % 3;
    if (d[0] == 2 && d[1] == 2) return {6'd0, 1'b0, 1'b1, dsum != 0};
    return {3'(d[0] * 3 + d[1]), w[11], w[7], w[3], 3'b001};
  endfunction

  task automatic report(bit ok, string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual pay=%b c/u/k=%b expected pay=%b c/u/k=%b",
               tag, act[8:3], act[2:0], exp[8:3], exp[2:0]);
    end
  endtask

  task automatic monitor(bit acc, logic [11:0] w, string tag);
    logic [8:0] act;
    act = {out_payload, out_corrected, out_uncorrectable, out_chk_err};
    if (prev_stall) report(out_valid === 1'b1 && act === prev_out, "R9 stall hold", act, prev_out);
    if (out_valid && out_ready) begin
      if (q_exp.size() == 0) report(0, "R9 spurious output", act, 9'd0);
      else begin
        logic [8:0] e;
        int c0;
        bit fr;
        string t;
        e = q_exp.pop_front(); c0 = q_cyc.pop_front(); fr = q_free.pop_front(); t = q_tag.pop_front();
        report(act === e, t, act, e);
        if (fr) report(cyc - c0 == 2, "R9 latency", 9'(cyc - c0), 9'd2);
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_out   = act;
    if (acc) begin
      q_exp.push_back(model(w)); q_cyc.push_back(cyc); q_free.push_back(!rnd_rdy); q_tag.push_back(tag);
    end
  endtask

  task automatic cycle(bit v, logic [11:0] w, string tag, output bit acc);
    bit rdy;
    @(negedge clk);
    rdy = rnd_rdy ? ($urandom % 4 != 0) : 1'b1;
    in_valid = v; in_word = w; out_ready = rdy;
    #1;
    acc = v && in_ready;
    monitor(acc, w, tag);
    cyc++;
  endtask

  task automatic send(logic [11:0] w, string tag);
    bit acc;
    do cycle(1'b1, w, tag, acc); while (!acc);
  endtask

  task automatic drain();
    bit acc;
    int n;
    n = 0;
    while ((q_exp.size() != 0 || out_valid) && n < 50) begin
      cycle(1'b0, 12'd0, "idle", acc);
      n++;
    end
    rnd_rdy = 0;
    cycle(1'b0, 12'd0, "idle", acc);
    report(q_exp.size() == 0, "R9 all results delivered", 9'(q_exp.size()), 9'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    report(out_valid === 1'b0, "R10 reset out_valid", {8'd0, out_valid}, 9'd0);
    rst_n = 1'b1;
    @(negedge clk);
    report(out_valid === 1'b0 && in_ready === 1'b1, "R10 after reset", {7'd0, out_valid, in_ready}, 9'd1);

    // R1 R2: clean round trip of every payload
    for (int p = 0; p < 64; p++) send(enc(p), "R2 round trip");
    drain();

    // R3: worked example, then every single-bit flip in every channel
    send({4'b1101, 4'b0101, 4'b1100}, "R3 worked example");
    for (int p = 0; p < 64; p++)
      for (int b = 0; b < 12; b++) send(enc(p) ^ (12'd1 << b), "R3 single flip");
    drain();

    // R4: weight 0 or 4 in one channel
    for (int p = 0; p < 64; p += 5)
      for (int ch = 0; ch < 3; ch++) begin
        logic [11:0] w;
        w = enc(p);
        w[11 - 4*ch -: 4] = 4'b0000; send(w, "R4 weight0 tie");
        w[11 - 4*ch -: 4] = 4'b1111; send(w, "R4 weight4 tie");
      end
    drain();

    // R5: two illegal symbols
    for (int p = 0; p < 64; p += 3) begin
      send(enc(p) ^ 12'h101, "R5 double erasure");
      send(enc(p) ^ 12'h820, "R5 double erasure");
      send(enc(p) ^ 12'h111, "R5 triple erasure");
    end
    drain();

    // R6: a legal symbol replaced by one of another subset
    for (int p = 0; p < 64; p += 3)
      for (int ch = 0; ch < 3; ch++) begin
        logic [11:0] w;
        logic [3:0] s;
        w = enc(p);
        s = nib(w, ch);
        w[11 - 4*ch -: 4] = sym_of((dig_of(s) + 1) % 3, s[3]);
        send(w, "R6 checksum mismatch");
      end
    drain();

    // R7: digit pair (2,2)
    send({4'b0110, 4'b1001, 4'b0110}, "R7 pair22 clean checksum");
    send({4'b1001, 4'b0111, 4'b0110}, "R7 pair22 after repair");
    send({4'b1001, 4'b1001, 4'b0011}, "R7 pair22 with mismatch");
    drain();

    // R8 R9: random stream with gaps and back-pressure
    rnd_rdy = 1;
    for (int i = 0; i < 3000; i++) begin
      bit acc;
      logic [11:0] w;
      int k;
      k = $urandom % 4;
      w = enc($urandom % 64);
      if (k == 1) w = w ^ (12'd1 << ($urandom % 12));
      else if (k == 2) w = 12'($urandom);
      if ($urandom % 3 == 0) cycle(1'b0, 12'd0, "idle", acc);
      else send(w, "R9 stream under back-pressure");
    end
    drain();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule